// File: doc/BRIEF.md
# Lockable SMRAM Window Controller

This block guards a protected region at the top of installed RAM. Two byte-wide control registers sit on a plain configuration write/read port: a main control register with open, close, lock and global-enable bits, and an extended register with a window-size field and a window-enable bit. From them the block decides whether each byte access arriving on its memory request port may reach the RAM model behind it. Reads that land inside an active window return 0xFF, and writes there are dropped.

Firmware sets the size and window-enable, then sets close and global-enable with open and lock cleared, and finally sets lock. Once locked, the configuration stays frozen until reset. Sizes are counted in "units" of `UNIT_BYTES` bytes, so a full-size memory can be scaled down for a model. The fixed sizes are 1, 2 and 8 units. A fourth encoding takes the parameter `EXT_UNITS`, and any size larger than RAM is clamped to the whole of RAM.

The memory port uses valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Exactly one response follows: `rsp_valid` rises on the next cycle. The response holds its data unchanged until `rsp_ready` is seen high. `req_ready` equals `!rsp_valid || rsp_ready`, so at most one response is ever outstanding.

Top module: `smram_guard`

## Requirements
- R1: After reset both control registers read 0x00, `rsp_valid` is low and `req_ready` is high.
- R2: While unlocked, the open bit (main register bit 6) reads back the last value written to it.
- R3: A write with the lock bit (bit 4) set leaves open at 0, even if the same write sets open. While locked, writes of 1 to open are ignored.
- R4: Lock stays set until reset, and reset clears it. While locked, global-enable (bit 3), lock and the whole extended register ignore writes. Close (bit 5) stays writable. After reset, open is writable again.
- R5: The main register implements only bits 6:3 and the extended register only bits 2:0; all other bits read 0. Configuration port select 0 is the main register and select 1 is the extended register.
- R6: Extended size field bits 2:1 select the window size: 00 is 1 unit, 01 is 2 units, 10 is 8 units, 11 is `EXT_UNITS`. Window-enable is extended bit 0.
- R7: The window starts at (`RAM_UNITS` minus size) × `UNIT_BYTES` and ends at the top of RAM. A size larger than `RAM_UNITS` covers all of RAM.
- R8: The window is active when global-enable and window-enable are set and open is clear. While it is active, reads inside it return 0xFF and writes inside it leave memory unchanged.
- R9: Outside an active window, every address is ordinary read/write memory that starts at 0x00. This includes the byte just below a locked window and any address when the window is inactive.
- R10: Each accepted request gets one response on the next cycle. A write response carries 0x00. A response held by low `rsp_ready` keeps its data stable, and `req_ready` stays low while it waits.
- R11: Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 main, 1 extended |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected register contents (combinational) |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte address, AW = clog2(RAM_UNITS*UNIT_BYTES) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 8 | Read data (0x00 for writes) |

## Verification
The hardest cases to reach are the window boundary under each size encoding and the clamped extended size. Each needs the full configure-then-lock sequence, and a reset before every encoding because lock freezes the size field. The bench therefore resets, configures and locks once per encoding. It then probes the last byte below the computed start and the first byte inside the window, using addresses that no other scenario touches, so the below-window byte is still at its initial zero. The clamp case comes from a second instance that shares every input but uses an extended size larger than RAM.

// File: rtl/smg_pkg.sv
package smg_pkg;
  // main control register bit positions
  localparam int CTL_OPEN  = 6;
  localparam int CTL_CLOSE = 5;
  localparam int CTL_LOCK  = 4;
  localparam int CTL_GEN   = 3;
  // extended register bit positions
  localparam int EXT_WEN   = 0;
  localparam int EXT_SZ_LO = 1;
  localparam int EXT_SZ_HI = 2;

  typedef enum logic [1:0] {
    WSZ_ONE   = 2'b00,
    WSZ_TWO   = 2'b01,
    WSZ_EIGHT = 2'b10,
    WSZ_EXT   = 2'b11
  } win_size_e;

  typedef struct packed {
    logic      open;
    logic      close;
    logic      lock;
    logic      gen;
    logic      wen;
    win_size_e size;
  } smg_ctl_t;
endpackage

// File: rtl/smg_regs.sv
module smg_regs
  import smg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output smg_ctl_t   ctl
);
  smg_ctl_t ctl_q;
  logic     unused_wbit;

  assign unused_wbit = cfg_wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        ctl_q.close <= cfg_wdata[CTL_CLOSE];
        if (!ctl_q.lock) begin
          ctl_q.open <= cfg_wdata[CTL_OPEN] & ~cfg_wdata[CTL_LOCK];
          ctl_q.gen  <= cfg_wdata[CTL_GEN];
          ctl_q.lock <= cfg_wdata[CTL_LOCK];
        end
      end else if (!ctl_q.lock) begin
        ctl_q.wen  <= cfg_wdata[EXT_WEN];
        ctl_q.size <= win_size_e'(cfg_wdata[EXT_SZ_HI:EXT_SZ_LO]);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_sel) begin
      cfg_rdata[CTL_OPEN]  = ctl_q.open;
      cfg_rdata[CTL_CLOSE] = ctl_q.close;
      cfg_rdata[CTL_LOCK]  = ctl_q.lock;
      cfg_rdata[CTL_GEN]   = ctl_q.gen;
    end else begin
      cfg_rdata[EXT_WEN]               = ctl_q.wen;
      cfg_rdata[EXT_SZ_HI:EXT_SZ_LO]   = ctl_q.size;
    end
  end

  assign ctl = ctl_q;

  AST_LOCK_OPEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |-> !ctl_q.open); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> ctl_q.lock); // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> ($stable(ctl_q.gen) && $stable(ctl_q.wen) && $stable(ctl_q.size))); // R4
endmodule

// File: rtl/smg_window.sv
module smg_window
  import smg_pkg::*;
#(
  parameter int RAM_UNITS  = 16,
  parameter int UNIT_BYTES = 64,
  parameter int EXT_UNITS  = 4,
  parameter int AW         = 10
) (
  input  smg_ctl_t        ctl,
  input  logic [AW-1:0]   addr,
  output logic            blocked
);
  localparam int BW   = AW + 1;
  localparam int U1   = (1 > RAM_UNITS) ? RAM_UNITS : 1;
  localparam int U2   = (2 > RAM_UNITS) ? RAM_UNITS : 2;
  localparam int U8   = (8 > RAM_UNITS) ? RAM_UNITS : 8;
  localparam int UEXT = (EXT_UNITS > RAM_UNITS) ? RAM_UNITS : EXT_UNITS;

  int          win_units;
  logic [BW-1:0] win_base;
  logic        active;
  logic        hit;
  logic        unused_close;

  assign unused_close = ctl.close;

  always_comb begin
    unique case (ctl.size)
      WSZ_ONE:   win_units = U1;
      WSZ_TWO:   win_units = U2;
      WSZ_EIGHT: win_units = U8;
      default:   win_units = UEXT;
    endcase
    win_base = BW'((RAM_UNITS - win_units) * UNIT_BYTES);
  end

  assign active  = ctl.gen & ctl.wen & ~ctl.open;
  assign hit     = ({1'b0, addr} >= win_base);
  assign blocked = active & hit;
endmodule

// File: rtl/smg_mem.sv
module smg_mem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  input  logic          blocked,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH] = '{default: 8'h00};
  logic       accept;
  logic [7:0] rd_next;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (accept && req_write && !blocked) begin
      mem[req_addr] <= req_wdata;
    end
  end

  always_comb begin
    if (req_write)    rd_next = 8'h00;
    else if (blocked) rd_next = 8'hFF;
    else              rd_next = mem[req_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
  AST_BLOCKED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && blocked) |=> (rsp_rdata == 8'hFF)); // R8
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smg_pkg::*;
#(
  parameter int RAM_UNITS  = 16,
  parameter int UNIT_BYTES = 64,
  parameter int EXT_UNITS  = 4,
  localparam int AW        = $clog2(RAM_UNITS * UNIT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_rdata
);
  smg_ctl_t ctl;
  logic     blocked;

  smg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ctl       (ctl)
  );

  smg_window #(
    .RAM_UNITS  (RAM_UNITS),
    .UNIT_BYTES (UNIT_BYTES),
    .EXT_UNITS  (EXT_UNITS),
    .AW         (AW)
  ) u_window (
    .ctl     (ctl),
    .addr    (req_addr),
    .blocked (blocked)
  );

  smg_mem #(.AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .blocked   (blocked),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  AST_OPEN_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.open |-> !blocked); // R9
endmodule

// File: tb/tb_smram_guard.sv
module tb_smram_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] cfg_rdata, rsp_rdata, cfg_rdata_b, rsp_rdata_b;
  logic req_ready, rsp_valid, req_ready_b, rsp_valid_b;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata));

  smram_guard #(.EXT_UNITS(20)) dut_big (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_b), .req_valid(req_valid),
    .req_ready(req_ready_b), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata_b));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic sel, output logic [7:0] d);
    @(negedge clk); cfg_sel = sel; #1 d = cfg_rdata;
  endtask

  task automatic mem_op(input logic wr, input int addr, input logic [7:0] wd,
                        output logic [7:0] rd, output logic [7:0] rd_b);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_write = wr;
    req_addr = AW'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; rd_b = rsp_rdata_b;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    do_reset();
    cfg_rd(1'b0, v); chk("R1 main reg", v, 8'h00);
    cfg_rd(1'b1, v); chk("R1 ext reg", v, 8'h00);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    chk("R1 req_ready", {7'd0, req_ready}, 8'h01);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    do_reset();
    cfg_wr(1'b0, 8'hEF); cfg_rd(1'b0, v); chk("R5 main bits", v, 8'h68);
    cfg_wr(1'b1, 8'hFF); cfg_rd(1'b1, v); chk("R5 ext bits", v, 8'h07);
  endtask

  task automatic t_open_lock();
    logic [7:0] v;
    do_reset();
    cfg_wr(1'b0, 8'h00); cfg_rd(1'b0, v); chk("R2 open clear", v, 8'h00);
    cfg_wr(1'b0, 8'h40); cfg_rd(1'b0, v); chk("R2 open set", v, 8'h40);
    cfg_wr(1'b0, 8'h58); cfg_rd(1'b0, v); chk("R3 lock forces open 0", v, 8'h18);
    cfg_wr(1'b0, 8'h40); cfg_rd(1'b0, v); chk("R3 R4 open ignored locked", v, 8'h18);
    cfg_wr(1'b0, 8'h20); cfg_rd(1'b0, v); chk("R4 close writable, gen frozen", v, 8'h38);
    cfg_wr(1'b1, 8'h07); cfg_rd(1'b1, v); chk("R4 ext frozen", v, 8'h00);
    do_reset();
    cfg_rd(1'b0, v); chk("R4 reset clears lock", v, 8'h00);
    cfg_wr(1'b0, 8'h40); cfg_rd(1'b0, v); chk("R4 open writable after reset", v, 8'h40);
  endtask

  task automatic t_size(input logic [1:0] code, input int units);
    logic [7:0] v, r, rb;
    int base;
    base = (16 - units) * 64;
    do_reset();
    cfg_wr(1'b1, {5'd0, code, 1'b1});
    cfg_wr(1'b0, 8'h28);
    cfg_wr(1'b0, 8'h38);
    cfg_rd(1'b0, v); chk("R6 locked main", v, 8'h38);
    mem_op(1'b0, base - 1, 8'h00, r, rb); chk("R9 below window init", r, 8'h00);
    mem_op(1'b1, base - 1, 8'h01, r, rb);
    mem_op(1'b0, base - 1, 8'h00, r, rb); chk("R9 below window rw", r, 8'h01);
    mem_op(1'b0, base, 8'h00, r, rb); chk("R6 R7 window start reads FF", r, 8'hFF);
    mem_op(1'b1, base, 8'h01, r, rb);
    mem_op(1'b0, base, 8'h00, r, rb); chk("R8 window write dropped", r, 8'hFF);
    if (code == 2'b11) begin
      mem_op(1'b0, 0, 8'h00, r, rb);
      chk("R7 clamped window covers addr 0", rb, 8'hFF);
      chk("R7 unclamped addr 0 open", r, 8'h00);
    end
  endtask

  task automatic t_inactive();
    logic [7:0] r, rb;
    do_reset();
    cfg_wr(1'b1, 8'h01);
    cfg_wr(1'b0, 8'h00);
    mem_op(1'b1, 1023, 8'h5A, r, rb);
    mem_op(1'b0, 1023, 8'h00, r, rb); chk("R9 gen clear passes", r, 8'h5A);
    cfg_wr(1'b0, 8'h48);
    mem_op(1'b0, 1023, 8'h00, r, rb); chk("R9 open passes", r, 8'h5A);
    cfg_wr(1'b0, 8'h08);
    mem_op(1'b0, 1023, 8'h00, r, rb); chk("R8 active blocks read", r, 8'hFF);
    mem_op(1'b1, 1023, 8'h77, r, rb);
    cfg_wr(1'b0, 8'h48);
    mem_op(1'b0, 1023, 8'h00, r, rb); chk("R8 blocked write left memory", r, 8'h5A);
  endtask

  task automatic t_handshake();
    logic [7:0] r, rb, held;
    do_reset();
    mem_op(1'b1, 5, 8'hC3, r, rb); chk("R10 write response zero", r, 8'h00);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(5);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rsp_valid next cycle", {7'd0, rsp_valid}, 8'h01);
    held = rsp_rdata; chk("R10 read data", held, 8'hC3);
    @(negedge clk);
    chk("R10 rsp held", {7'd0, rsp_valid}, 8'h01);
    chk("R10 data stable", rsp_rdata, held);
    chk("R10 req_ready low while held", {7'd0, req_ready}, 8'h00);
    rsp_ready = 1'b1;
    #1 chk("R10 req_ready with rsp_ready", {7'd0, req_ready}, 8'h01);
    @(negedge clk);
    chk("R10 rsp drained", {7'd0, rsp_valid}, 8'h00);
  endtask

  task automatic t_persist();
    logic [7:0] r, rb;
    do_reset();
    mem_op(1'b1, 0, 8'h32, r, rb);
    do_reset();
    mem_op(1'b0, 0, 8'h00, r, rb); chk("R11 memory survives reset", r, 8'h32);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fields();
    t_open_lock();
    t_size(2'b00, 1);
    t_size(2'b01, 2);
    t_size(2'b10, 8);
    t_size(2'b11, 4);
    t_inactive();
    t_handshake();
    t_persist();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule